// File: doc/BRIEF.md
# Dual-Direction Message Queue Controller

This block keeps the bookkeeping for one message queue of `DEPTH` slots. The slots themselves live elsewhere. A configuration bit turns the queue into either a transmit queue or a receive queue. The block holds a head index, a tail index and a fill count. It drives empty, half and full status flags. It combines the status conditions and two sticky event flags into a single interrupt request, each through its own enable.

Software reaches the block through one control write port. Each write loads the configuration byte and can carry several action bits in the same word: send request, slot advance, queue flush, and write-one-to-clear for the two sticky flags. The bus-side engine is represented by single-cycle pulses: a message sent, attempts exhausted, a message stored, and a remote frame received. The block answers the engine with a held send request and a one-cycle abort pulse. An action is applied at the clock edge that samples it. All outputs are registered state, or logic driven only by registered state.

Write word `ctl_wdata`: [0] direction (1 transmit, 0 receive), [1] auto-answer of remote frames, [2] timestamp capture, [3] exhausted-interrupt enable, [4] overflow-interrupt enable, [5] edge enable (empty in transmit, full in receive), [6] half enable, [7] availability enable (not full in transmit, not empty in receive), [8] send request, [9] slot advance, [10] flush, [11] clear overflow, [12] clear exhausted. Read word `ctl_rdata`: [7:0] configuration, [8] send request, [9] always 0, [10] flush in progress. Actions that depend on direction use the direction stored before the write.

Top module: `msgq_ctrl`

## Requirements
- R1: While reset is held and just after it is released, head, tail, count, configuration, send request and both sticky flags read 0, and the flush bit (ctl_rdata[10]) reads 1. The next edge clears the flush bit.
- R2: A write with bit 10 set raises the flush bit at that edge. At the following edge, head, tail and count go to 0 and the flush bit clears. Queue events in the clearing cycle are ignored.
- R3: In transmit mode, a slot advance (bit 9) moves the head one slot, modulo DEPTH, unless the queue is full. A tx_sent pulse moves the tail one slot unless the queue is empty. The count follows in the same cycle and never exceeds DEPTH.
- R4: In receive mode, an rx_stored pulse moves the head one slot unless the queue is full. A slot advance moves the tail one slot unless the queue is empty.
- R5: In receive mode, an rx_stored pulse that arrives while the queue is full is dropped and sets ovf_flag. That flag stays set until a write with bit 11 set. A new drop in the same cycle wins over the clear.
- R6: In transmit mode, a write with bit 8 set raises send_req. send_req clears at the edge where a tx_sent pulse empties the queue.
- R7: In transmit mode, a write with bit 8 clear while send_req is 1 clears send_req and pulses abort_req for exactly one cycle.
- R8: In receive mode, bit 8 of a write leaves send_req unchanged.
- R9: In transmit mode with bit 1 set, an rx_remote pulse sets send_req, and this wins over any other update in the same cycle. With bit 1 clear, rx_remote leaves send_req unchanged.
- R10: fifo_empty is count == 0 and fifo_full is count == DEPTH. fifo_half is 2*count <= DEPTH in transmit mode and 2*count >= DEPTH in receive mode.
- R11: irq is the OR of (bit 3 AND exh_flag), (bit 4 AND ovf_flag), (bit 5 AND empty/full), (bit 6 AND fifo_half) and (bit 7 AND not-full/not-empty), with the status conditions chosen by direction.
- R12: A write updates configuration bit 2 only while cfg_mode is 1. The other configuration bits update on every write.
- R13: A tx_exhausted pulse sets exh_flag. That flag stays set until a write with bit 12 set, and a new pulse in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Controller is in configuration mode |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 13 | Control write word |
| ctl_rdata | output | 11 | Control read word |
| tx_sent | input | 1 | Engine sent one message successfully |
| tx_exhausted | input | 1 | Engine ran out of transmit attempts |
| rx_stored | input | 1 | Engine stored one received message |
| rx_remote | input | 1 | Engine received a remote frame |
| send_req | output | 1 | Send request held toward the engine |
| abort_req | output | 1 | One-cycle abort pulse toward the engine |
| head_idx | output | IW = clog2(DEPTH) | Head slot index |
| tail_idx | output | IW | Tail slot index |
| fill_count | output | CW = clog2(DEPTH+1) | Occupied slots |
| fifo_empty | output | 1 | Queue empty |
| fifo_half | output | 1 | Half empty (transmit) or half full (receive) |
| fifo_full | output | 1 | Queue full |
| ovf_flag | output | 1 | Sticky receive overflow |
| exh_flag | output | 1 | Sticky attempts exhausted |
| irq | output | 1 | Interrupt request |

## Verification
A head, tail or count that goes wrong shows up on head_idx, tail_idx, fill_count and the three status flags one cycle after the event that caused it. A count that is off by one stays wrong until the next flush, so every later comparison in the run also fails. A wrong send request or abort decision is visible on send_req or abort_req at the edge after the write or engine pulse. A mistake in picking enables by direction appears on irq as soon as the stored state reaches the affected condition. Because of this, a reference model that steps once per cycle and compares every output at every cycle catches each of these faults within one cycle.

// File: rtl/msgq_pkg.sv
package msgq_pkg;

    localparam int WR_W     = 13;
    localparam int RD_W     = 11;
    localparam int B_SEND   = 8;
    localparam int B_INCR   = 9;
    localparam int B_FLUSH  = 10;
    localparam int B_CLROVF = 11;
    localparam int B_CLREXH = 12;

    typedef struct packed {
        logic ie_avail;
        logic ie_half;
        logic ie_edge;
        logic ie_ovf;
        logic ie_exh;
        logic ts_en;
        logic auto_rmt;
        logic dir_tx;
    } cfg_t;

    typedef struct packed {
        logic empty;
        logic half;
        logic full;
    } stat_t;

    function automatic logic half_hit(input logic tx, input int unsigned cnt,
                                      input int unsigned depth);
        return tx ? (2 * cnt <= depth) : (2 * cnt >= depth);
    endfunction

endpackage

// File: rtl/msgq_ptrs.sv
module msgq_ptrs #(
    parameter  int DEPTH = 8,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push_req,
    input  logic          pop_req,
    output logic [IW-1:0] head,
    output logic [IW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          drop,
    output logic          drain_last
);

    function automatic logic [IW-1:0] next_slot(input logic [IW-1:0] i);
        return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
    endfunction

    logic is_full;

    assign is_full    = (count == CW'(DEPTH));
    assign push_ok    = !flush && push_req && !is_full;
    assign pop_ok     = !flush && pop_req && (count != '0);
    assign drop       = !flush && push_req && is_full;
    assign drain_last = pop_ok && !push_ok && (count == CW'(1));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push_ok) head <= next_slot(head);
            if (pop_ok)  tail <= next_slot(tail);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_flush_zero_R2: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && head == '0 && tail == '0));

    assert_drop_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (drop && !pop_req) |=> ($stable(head) && $stable(count)));

endmodule

// File: rtl/msgq_txreq.sv
module msgq_txreq (
    input  logic clk,
    input  logic rst,
    input  logic tx_mode,
    input  logic wr,
    input  logic wr_send,
    input  logic drain_last,
    input  logic remote,
    input  logic auto_rmt,
    output logic send_req,
    output logic abort_pulse
);

    logic send_d, abort_d;

    always_comb begin
        send_d  = send_req;
        abort_d = 1'b0;
        if (tx_mode && wr) begin
            if (wr_send) begin
                send_d = 1'b1;
            end else if (send_req) begin
                send_d  = 1'b0;
                abort_d = 1'b1;
            end
        end
        if (tx_mode && drain_last)          send_d = 1'b0;
        if (tx_mode && auto_rmt && remote)  send_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            send_req    <= 1'b0;
            abort_pulse <= 1'b0;
        end else begin
            send_req    <= send_d;
            abort_pulse <= abort_d;
        end
    end

    assert_rx_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !tx_mode |=> $stable(send_req));

    assert_abort_cause_R7: assert property (@(posedge clk) disable iff (rst)
        abort_pulse |-> $past(send_req));

    assert_remote_set_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_mode && auto_rmt && remote) |=> send_req);

endmodule

// File: rtl/msgq_irq.sv
module msgq_irq
    import msgq_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_tx,
    input  logic [4:0]    ie,
    input  logic [CW-1:0] count,
    input  logic          rx_drop,
    input  logic          exh_in,
    input  logic          clr_ovf,
    input  logic          clr_exh,
    output stat_t         stat,
    output logic          ovf_flag,
    output logic          exh_flag,
    output logic          irq
);

    logic ie_exh, ie_ovf, ie_edge, ie_half, ie_avail;
    logic lvl_src;

    assign {ie_avail, ie_half, ie_edge, ie_ovf, ie_exh} = ie;

    assign stat.empty = (count == '0);
    assign stat.full  = (count == CW'(DEPTH));
    assign stat.half  = half_hit(dir_tx, int'(count), DEPTH);

    always_comb begin
        if (dir_tx)
            lvl_src = (ie_edge & stat.empty) | (ie_half & stat.half) | (ie_avail & ~stat.full);
        else
            lvl_src = (ie_edge & stat.full) | (ie_half & stat.half) | (ie_avail & ~stat.empty);
    end

    assign irq = lvl_src | (ie_ovf & ovf_flag) | (ie_exh & exh_flag);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag <= 1'b0;
            exh_flag <= 1'b0;
        end else begin
            ovf_flag <= rx_drop | (ovf_flag & ~clr_ovf);
            exh_flag <= exh_in  | (exh_flag & ~clr_exh);
        end
    end

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !clr_ovf) |=> ovf_flag);

    assert_exh_sticky_R13: assert property (@(posedge clk) disable iff (rst)
        (exh_flag && !clr_exh) |=> exh_flag);

    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (ie == 5'b0) |-> !irq);

endmodule

// File: rtl/msgq_ctrl.sv
module msgq_ctrl
    import msgq_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_mode,
    input  logic            ctl_wr,
    input  logic [WR_W-1:0] ctl_wdata,
    output logic [RD_W-1:0] ctl_rdata,
    input  logic            tx_sent,
    input  logic            tx_exhausted,
    input  logic            rx_stored,
    input  logic            rx_remote,
    output logic            send_req,
    output logic            abort_req,
    output logic [IW-1:0]   head_idx,
    output logic [IW-1:0]   tail_idx,
    output logic [CW-1:0]   fill_count,
    output logic            fifo_empty,
    output logic            fifo_half,
    output logic            fifo_full,
    output logic            ovf_flag,
    output logic            exh_flag,
    output logic            irq
);

    cfg_t  cfg_q, cfg_w;
    stat_t stat;
    logic  flush_q;
    logic  incr, push_req, pop_req, push_ok, pop_ok, drop, drain_last;

    always_comb begin
        cfg_w = cfg_t'(ctl_wdata[7:0]);
        if (!cfg_mode) cfg_w.ts_en = cfg_q.ts_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            flush_q <= 1'b1;
        end else begin
            if (ctl_wr) cfg_q <= cfg_w;
            flush_q <= ctl_wr & ctl_wdata[B_FLUSH];
        end
    end

    assign incr     = ctl_wr & ctl_wdata[B_INCR];
    assign push_req = cfg_q.dir_tx ? incr    : rx_stored;
    assign pop_req  = cfg_q.dir_tx ? tx_sent : incr;

    msgq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush_q),
        .push_req   (push_req),
        .pop_req    (pop_req),
        .head       (head_idx),
        .tail       (tail_idx),
        .count      (fill_count),
        .push_ok    (push_ok),
        .pop_ok     (pop_ok),
        .drop       (drop),
        .drain_last (drain_last)
    );

    msgq_txreq u_txreq (
        .clk         (clk),
        .rst         (rst),
        .tx_mode     (cfg_q.dir_tx),
        .wr          (ctl_wr),
        .wr_send     (ctl_wdata[B_SEND]),
        .drain_last  (drain_last),
        .remote      (rx_remote),
        .auto_rmt    (cfg_q.auto_rmt),
        .send_req    (send_req),
        .abort_pulse (abort_req)
    );

    msgq_irq #(.DEPTH(DEPTH)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .dir_tx   (cfg_q.dir_tx),
        .ie       ({cfg_q.ie_avail, cfg_q.ie_half, cfg_q.ie_edge, cfg_q.ie_ovf, cfg_q.ie_exh}),
        .count    (fill_count),
        .rx_drop  (drop & ~cfg_q.dir_tx),
        .exh_in   (tx_exhausted),
        .clr_ovf  (ctl_wr & ctl_wdata[B_CLROVF]),
        .clr_exh  (ctl_wr & ctl_wdata[B_CLREXH]),
        .stat     (stat),
        .ovf_flag (ovf_flag),
        .exh_flag (exh_flag),
        .irq      (irq)
    );

    assign fifo_empty = stat.empty;
    assign fifo_half  = stat.half;
    assign fifo_full  = stat.full;
    assign ctl_rdata  = {flush_q, 1'b0, send_req, cfg_q};

    assert_flush_done_R2: assert property (@(posedge clk) disable iff (rst)
        (flush_q && !(ctl_wr && ctl_wdata[B_FLUSH])) |=> !flush_q);

    assert_ts_lock_R12: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> $stable(cfg_q.ts_en));

    assert_push_pop_excl_R3: assert property (@(posedge clk) disable iff (rst)
        flush_q |-> !(push_ok || pop_ok));

endmodule

// File: tb/tb_msgq_ctrl.sv
`timescale 1ns/1ps
module tb_msgq_ctrl;

    localparam int D  = 8;
    localparam int IW = 3;
    localparam int CW = 4;
    localparam realtime TCLK = 20ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_mode = 1'b0, ctl_wr = 1'b0;
    logic [12:0] ctl_wdata = '0;
    logic tx_sent = 0, tx_exhausted = 0, rx_stored = 0, rx_remote = 0;
    logic [10:0] ctl_rdata;
    logic send_req, abort_req, fifo_empty, fifo_half, fifo_full, ovf_flag, exh_flag, irq;
    logic [IW-1:0] head_idx, tail_idx;
    logic [CW-1:0] fill_count;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] m_cfg;
    logic m_flush, m_send, m_abort, m_ovf, m_exh;
    int m_head, m_tail, m_cnt;

    always #(TCLK/2) clk = ~clk;

    msgq_ctrl #(.DEPTH(D)) dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .tx_sent(tx_sent), .tx_exhausted(tx_exhausted),
        .rx_stored(rx_stored), .rx_remote(rx_remote), .send_req(send_req),
        .abort_req(abort_req), .head_idx(head_idx), .tail_idx(tail_idx),
        .fill_count(fill_count), .fifo_empty(fifo_empty), .fifo_half(fifo_half),
        .fifo_full(fifo_full), .ovf_flag(ovf_flag), .exh_flag(exh_flag), .irq(irq)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_half();
        return m_cfg[0] ? (2 * m_cnt <= D) : (2 * m_cnt >= D);
    endfunction

    function automatic logic exp_irq();
        logic emp, ful, lvl;
        emp = (m_cnt == 0);
        ful = (m_cnt == D);
        if (m_cfg[0]) lvl = (m_cfg[5] & emp) | (m_cfg[6] & exp_half()) | (m_cfg[7] & ~ful);
        else          lvl = (m_cfg[5] & ful) | (m_cfg[6] & exp_half()) | (m_cfg[7] & ~emp);
        return lvl | (m_cfg[4] & m_ovf) | (m_cfg[3] & m_exh);
    endfunction

    task automatic cmp_all();
        string pt;
        pt = m_cfg[0] ? "R3" : "R4";
        chk(pt, "head", int'(head_idx), m_head);
        chk(pt, "tail", int'(tail_idx), m_tail);
        chk(pt, "count", int'(fill_count), m_cnt);
        chk("R10", "empty", int'(fifo_empty), int'(m_cnt == 0));
        chk("R10", "full", int'(fifo_full), int'(m_cnt == D));
        chk("R10", "half", int'(fifo_half), int'(exp_half()));
        chk("R5", "ovf", int'(ovf_flag), int'(m_ovf));
        chk("R13", "exh", int'(exh_flag), int'(m_exh));
        chk("R6", "send", int'(send_req), int'(m_send));
        chk("R7", "abort", int'(abort_req), int'(m_abort));
        chk("R11", "irq", int'(irq), int'(exp_irq()));
        chk("R12", "cfg", int'(ctl_rdata[7:0]), int'(m_cfg));
        chk("R2", "flush", int'(ctl_rdata[10]), int'(m_flush));
    endtask

    task automatic model_update(input logic wr, input logic [12:0] wd, input logic sent,
                                input logic ex, input logic st, input logic rm, input logic cm);
        logic tx, incr, push_r, pop_r, push, pop, drop, s, ab;
        int nc;
        tx = m_cfg[0];
        incr = wr & wd[9];
        push_r = tx ? incr : st;
        pop_r  = tx ? sent : incr;
        push = !m_flush && push_r && m_cnt != D;
        pop  = !m_flush && pop_r && m_cnt != 0;
        drop = !m_flush && !tx && push_r && m_cnt == D;
        nc = m_flush ? 0 : m_cnt + int'(push) - int'(pop);
        s = m_send; ab = 0;
        if (tx && wr) begin
            if (wd[8]) s = 1;
            else if (m_send) begin s = 0; ab = 1; end
        end
        if (tx && pop && nc == 0) s = 0;
        if (tx && m_cfg[1] && rm) s = 1;
        if (wr && wd[11]) m_ovf = 0;
        if (drop) m_ovf = 1;
        if (wr && wd[12]) m_exh = 0;
        if (ex) m_exh = 1;
        if (m_flush) begin
            m_head = 0; m_tail = 0;
        end else begin
            if (push) m_head = (m_head + 1) % D;
            if (pop)  m_tail = (m_tail + 1) % D;
        end
        m_cnt = nc; m_send = s; m_abort = ab;
        m_flush = wr && wd[10];
        if (wr) begin
            m_cfg[7:3] = wd[7:3];
            m_cfg[1:0] = wd[1:0];
            if (cm) m_cfg[2] = wd[2];
        end
    endtask

    task automatic step(input logic wr, input logic [12:0] wd, input logic sent, input logic ex,
                        input logic st, input logic rm, input logic cm);
        ctl_wr = wr; ctl_wdata = wd; tx_sent = sent; tx_exhausted = ex;
        rx_stored = st; rx_remote = rm; cfg_mode = cm;
        @(posedge clk);
        model_update(wr, wd, sent, ex, st, rm, cm);
        @(negedge clk);
        ctl_wr = 0; tx_sent = 0; tx_exhausted = 0; rx_stored = 0; rx_remote = 0;
        cmp_all();
    endtask

    task automatic idle();
        step(0, '0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(input logic [12:0] wd);
        step(1, wd, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_cfg = '0; m_flush = 1; m_send = 0; m_abort = 0; m_ovf = 0; m_exh = 0;
        m_head = 0; m_tail = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1: state right after reset release
        chk("R1", "rdata after reset", int'(ctl_rdata), 11'h400);
        chk("R1", "count after reset", int'(fill_count), 0);
        chk("R1", "flags after reset", int'({ovf_flag, exh_flag, send_req}), 0);
        idle();
        chk("R1", "flush cleared", int'(ctl_rdata[10]), 0);

        // Receive mode: fill, overflow, clear (R4, R5, R10)
        wr(13'h0E0);
        for (int i = 0; i < D; i++) step(0, '0, 0, 0, 1, 0, 0);
        chk("R10", "full after fill", int'(fifo_full), 1);
        step(0, '0, 0, 0, 1, 0, 0);
        chk("R5", "overflow set", int'(ovf_flag), 1);
        chk("R5", "head held on drop", int'(head_idx), 0);
        wr(13'h0E0 | 13'h200);
        chk("R4", "tail after advance", int'(tail_idx), 1);
        wr(13'h0E0 | 13'h800);
        chk("R5", "overflow cleared", int'(ovf_flag), 0);
        // R8: send request ignored in receive mode
        wr(13'h100);
        chk("R8", "send in rx mode", int'(send_req), 0);

        // Transmit mode (R2, R3, R6, R7, R9)
        wr(13'h001 | 13'h400);
        idle();
        chk("R2", "count after flush", int'(fill_count), 0);
        for (int i = 0; i < 3; i++) wr(13'h001 | 13'h200);
        chk("R3", "head after loads", int'(head_idx), 3);
        step(0, '0, 0, 0, 0, 1, 0);
        chk("R9", "remote ignored when disabled", int'(send_req), 0);
        wr(13'h003);
        step(0, '0, 0, 0, 0, 1, 0);
        chk("R9", "remote sets send", int'(send_req), 1);
        wr(13'h003);
        chk("R7", "abort pulse", int'(abort_req), 1);
        chk("R7", "send cleared by abort", int'(send_req), 0);
        idle();
        chk("R7", "abort one cycle", int'(abort_req), 0);
        wr(13'h103);
        step(0, '0, 1, 0, 0, 0, 0);
        step(0, '0, 1, 0, 0, 0, 0);
        chk("R6", "send held while queued", int'(send_req), 1);
        step(0, '0, 1, 0, 0, 0, 0);
        chk("R6", "send auto-cleared", int'(send_req), 0);
        chk("R3", "empty after drain", int'(fifo_empty), 1);

        // R12: timestamp bit needs configuration mode
        step(1, 13'h005, 0, 0, 0, 0, 0);
        chk("R12", "ts locked", int'(ctl_rdata[2]), 0);
        step(1, 13'h005, 0, 0, 0, 0, 1);
        chk("R12", "ts written", int'(ctl_rdata[2]), 1);

        // R13 and R11: exhausted flag drives irq through its enable
        step(1, 13'h009, 0, 1, 0, 0, 0);
        chk("R13", "exh set", int'(exh_flag), 1);
        chk("R11", "irq from exh", int'(irq), 1);
        step(1, 13'h1009, 0, 1, 0, 0, 0);
        chk("R13", "set wins over clear", int'(exh_flag), 1);

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            logic [12:0] wd;
            logic w;
            w  = ($urandom % 4) == 0;
            wd = 13'($urandom);
            wd[10] = ($urandom % 20) == 0;
            wd[11] = ($urandom % 3) == 0;
            wd[12] = ($urandom % 3) == 0;
            if (($urandom % 8) != 0) wd[0] = m_cfg[0];
            step(w, wd, ($urandom % 3) == 0, ($urandom % 16) == 0,
                 ($urandom % 2) == 0, ($urandom % 8) == 0, ($urandom % 2) == 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule